// File: doc/BRIEF.md
# Reciprocal Counter Gating Synchronizer

This block is the gating front end of a reciprocal frequency and period counter. It watches a measured input signal and keeps two counters. The sample counter counts rising edges of the measured input. The time counter counts cycles of the reference clock over the same interval. The system clock serves as the reference clock. It must run at least twice as fast as the fastest measured input. The measured input passes through a two-flop synchronizer, and a rising-edge detector follows it.

Gating happens in two stages. The stage-1 flag opens and closes only on a detected input edge, and it gates the sample counter. The busy flag follows the stage-1 flag one reference cycle later, and it gates the time counter. As a result, both counters cover the same whole number of input periods. A controller reaches the period as time count divided by sample count, and the frequency as the inverse ratio. The controller lowers the active-low arm input to start a measurement and raises it to ask for the end. In gated mode, an active-low window input also limits counting, so a single measurement can add up counts over several separate windows.

Top module: `recip_gate`

## Requirements
- R1: A rising edge of `sig_in` is detected at the second `clk` edge after the edge that first samples it high. `smp_cnt` increments by one at each detected edge for which the stage-1 flag was already open, and changes at no other time except on clear.
- R2: `tim_cnt` increments by one on every `clk` edge at which `busy` was high.
- R3: `arm_n` is active low. At a `clk` edge where `arm_n` is low and was high at the previous edge, both counters and both overflow flags are cleared.
- R4: At each detected edge, the stage-1 flag is loaded with the request. The request is true when `arm_n` is low and either `gated` is low or `win_n` is low. Between detected edges the stage-1 flag holds its value.
- R5: `busy` equals the stage-1 flag delayed by one `clk` cycle. For a periodic input of period P cycles in non-gated mode, a finished measurement therefore gives `tim_cnt` = P × `smp_cnt`.
- R6: An asynchronous active-low `rst_n` closes both gate flags together and zeroes both counters and both overflow flags.
- R7: A measurement stays open after `arm_n` rises until the next detected edge, and `busy` then falls one cycle later.
- R8: With `gated` high, counting is suspended while `win_n` is high (as sampled at detected edges), and it resumes in a later low window without the counters being cleared.
- R9: A counter increment from all ones wraps the counter to zero and sets that counter's overflow flag. The flag stays set until the next clear or reset.
- R10: After `busy` falls, both counters and both flags hold their values while `arm_n` stays high, even if `sig_in` keeps toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Measured input (asynchronous) |
| arm_n | input | 1 | Active-low measurement arm |
| gated | input | 1 | Selects gated mode |
| win_n | input | 1 | Active-low counting window used in gated mode |
| busy | output | 1 | Synchronized gate state; high while time counting |
| smp_cnt | output | W | Sample (input edge) count |
| tim_cnt | output | W | Time (reference cycle) count |
| smp_ovf | output | 1 | Sticky sample-counter wrap flag |
| tim_ovf | output | 1 | Sticky time-counter wrap flag |

## Verification
The bench releases `arm_n` between input edges. A design that closed the gate on `arm_n` itself, rather than on the next input edge, would end the time count on a fraction of a period and break the P × samples relation. Very short arm pulses and window toggles that land next to detected edges check that the stage-1 flag samples the request only at edges. A design that sampled it every cycle would add or drop samples. Long measurements with a narrowed counter check wrapping and the sticky flags, and later re-arms check that clearing happens once, on the falling edge of `arm_n`. A reset during an open measurement checks that both flags close at the same moment.

// File: rtl/recip_gate.sv
module recip_gate #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sig_in,
  input  logic         arm_n,
  input  logic         gated,
  input  logic         win_n,
  output logic         busy,
  output logic [W-1:0] smp_cnt,
  output logic [W-1:0] tim_cnt,
  output logic         smp_ovf,
  output logic         tim_ovf
);

  logic [2:0] sp;
  logic       arm_q;
  logic       g1;
  logic       g2;

  wire det   = sp[1] & ~sp[2];
  wire req   = ~arm_n & (~gated | ~win_n);
  wire clr   = ~arm_n & arm_q;
  wire s_inc = det & g1;
  wire t_inc = g2;

  assign busy = g2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sp    <= '0;
      arm_q <= 1'b1;
      g1    <= 1'b0;
      g2    <= 1'b0;
    end else begin
      sp    <= {sp[1:0], sig_in};
      arm_q <= arm_n;
      if (det) g1 <= req;
      g2    <= g1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp_cnt <= '0;
      smp_ovf <= 1'b0;
    end else if (clr) begin
      smp_cnt <= '0;
      smp_ovf <= 1'b0;
    end else if (s_inc) begin
      smp_cnt <= smp_cnt + 1'b1;
      if (&smp_cnt) smp_ovf <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tim_cnt <= '0;
      tim_ovf <= 1'b0;
    end else if (clr) begin
      tim_cnt <= '0;
      tim_ovf <= 1'b0;
    end else if (t_inc) begin
      tim_cnt <= tim_cnt + 1'b1;
      if (&tim_cnt) tim_ovf <= 1'b1;
    end

endmodule

// File: rtl/recip_gate_chk.sv
module recip_gate_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         clr,
  input logic         g1,
  input logic         busy,
  input logic [W-1:0] smp_cnt,
  input logic [W-1:0] tim_cnt,
  input logic         smp_ovf,
  input logic         tim_ovf
);

  p_time_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> tim_cnt == W'($past(tim_cnt) + 1'b1));

  p_time_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !clr) |=> $stable(tim_cnt));

  p_smp_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!g1 && !clr) |=> $stable(smp_cnt));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (smp_cnt == '0 && tim_cnt == '0 && !smp_ovf && !tim_ovf));

  p_busy_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(g1));

  p_busy_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !$past(g1));

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((tim_ovf && !clr) |=> tim_ovf));

  p_sovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((smp_ovf && !clr) |=> smp_ovf));

endmodule

bind recip_gate recip_gate_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .g1(g1), .busy(busy),
  .smp_cnt(smp_cnt), .tim_cnt(tim_cnt), .smp_ovf(smp_ovf), .tim_ovf(tim_ovf)
);

// File: tb/test_recip_gate.sv
module test_recip_gate;
  localparam int BW = 8;
  localparam int MASK = (1 << BW) - 1;
  localparam int N = 4096;

  logic clk = 1'b0, rst_n = 1'b0, sig_in = 1'b0, arm_n = 1'b1, gated = 1'b0, win_n = 1'b1;
  logic busy, smp_ovf, tim_ovf;
  logic [BW-1:0] smp_cnt, tim_cnt;

  always #2 clk = ~clk;

  recip_gate #(.W(BW)) i_recip_gate (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .arm_n(arm_n), .gated(gated),
    .win_n(win_n), .busy(busy), .smp_cnt(smp_cnt), .tim_cnt(tim_cnt),
    .smp_ovf(smp_ovf), .tim_ovf(tim_ovf)
  );

  int errors = 0, checks = 0, idx = 0, ph = 0;
  bit done = 0;
  bit va[N], aa[N], wa[N], ga[N];
  int m_smp, m_tim;
  bit m_busy, m_sovf, m_tovf;

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // expected state after edges 3..n-1 of the current record
  function automatic void model(int n);
    bit g1 = 0, g2 = 0;
    m_smp = 0; m_tim = 0; m_sovf = 0; m_tovf = 0;
    for (int j = 3; j < n; j++) begin
      bit det = va[j-2] & ~va[j-3];
      bit req = !aa[j] && (!ga[j] || !wa[j]);
      bit clr = !aa[j] && aa[j-1];
      bit ng1 = det ? req : g1;
      if (clr) begin
        m_smp = 0; m_tim = 0; m_sovf = 0; m_tovf = 0;
      end else begin
        if (det && g1) begin
          if (m_smp == MASK) m_sovf = 1;
          m_smp = (m_smp + 1) & MASK;
        end
        if (g2) begin
          if (m_tim == MASK) m_tovf = 1;
          m_tim = (m_tim + 1) & MASK;
        end
      end
      g2 = g1; g1 = ng1;
    end
    m_busy = g2;
  endfunction

  task automatic step(bit s, bit a, bit w, bit g);
    sig_in = s; arm_n = a; win_n = w; gated = g;
    va[idx] = s; aa[idx] = a; wa[idx] = w; ga[idx] = g;
    @(posedge clk); @(negedge clk);
    idx++;
  endtask

  function automatic bit wave(int p, int h);
    return (ph % p) < h;
  endfunction

  task automatic check_all(string tag);
    model(idx);
    chk({tag, " R1 smp_cnt"}, int'(smp_cnt), m_smp);
    chk({tag, " R2 tim_cnt"}, int'(tim_cnt), m_tim);
    chk({tag, " R7 busy"}, int'(busy), int'(m_busy));
    chk({tag, " R9 ovf"}, int'({smp_ovf, tim_ovf}), int'({m_sovf, m_tovf}));
  endtask

  task automatic meas(int p, int h, int alen, bit g, int wrate, bit ratio);
    bit w = 1'b0;
    idx = 0; ph = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, g);
    for (int i = 0; i < alen; i++) begin
      if (g && ($urandom % wrate) == 0) w = ~w;
      step(wave(p, h), 1'b0, g ? w : 1'b1, g);
      ph++;
      if (i == 0) begin
        model(idx);
        chk("R3 clear on arm", int'(smp_cnt) + int'(tim_cnt) + int'(smp_ovf) + int'(tim_ovf), 0);
      end
    end
    check_all(g ? "R8 gated mid" : "R4 mid");
    for (int i = 0; i < 2 * p + 4; i++) begin
      step(wave(p, h), 1'b1, 1'b1, g);
      ph++;
    end
    check_all(g ? "R8 gated end" : "R7 end");
    if (ratio && !m_sovf && !m_tovf)
      chk("R5 tim = P*smp", int'(tim_cnt), p * int'(smp_cnt));
    for (int i = 0; i < 12; i++) begin
      step(wave(p, h), 1'b1, 1'b0, g);
      ph++;
    end
    check_all("R10 hold");
  endtask

  initial begin
    int p, h;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R6 reset busy", int'(busy), 0);
    chk("R6 reset counts", int'(smp_cnt) + int'(tim_cnt) + int'(smp_ovf) + int'(tim_ovf), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed: release between edges, long period
    meas(9, 4, 40, 1'b0, 1, 1'b1);
    // directed: arm pulse of one cycle
    meas(9, 3, 1, 1'b0, 1, 1'b1);
    // directed: fastest input
    meas(2, 1, 30, 1'b0, 1, 1'b1);
    // directed: overflow of both counters
    meas(2, 1, 600, 1'b0, 1, 1'b0);
    chk("R9 both ovf set", int'({smp_ovf, tim_ovf}), 3);
    // re-arm clears overflow
    meas(5, 2, 20, 1'b0, 1, 1'b1);
    for (int k = 0; k < 10; k++) begin
      p = 2 + ($urandom % 9);
      h = 1 + ($urandom % (p - 1));
      meas(p, h, 10 + ($urandom % 120), 1'b0, 1, 1'b1);
    end
    for (int k = 0; k < 8; k++) begin
      p = 2 + ($urandom % 7);
      h = 1 + ($urandom % (p - 1));
      meas(p, h, 40 + ($urandom % 200), 1'b1, 3 + ($urandom % 10), 1'b0);
    end
    // reset during an open measurement
    idx = 0; ph = 0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) begin step(wave(3, 1), 1'b0, 1'b1, 1'b0); ph++; end
    chk("R7 busy open", int'(busy), 1);
    rst_n = 1'b0;
    #1;
    chk("R6 async busy", int'(busy), 0);
    chk("R6 async counts", int'(smp_cnt) + int'(tim_cnt), 0);
    @(negedge clk);
    arm_n = 1'b1;
    rst_n = 1'b1;
    @(negedge clk);
    meas(4, 2, 25, 1'b0, 1, 1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule